// File: doc/BRIEF.md
# Dual-Channel Byte-Loaded Converter Code Registers

This block is the digital register front end of a two-channel 12-bit converter that hangs off an 8-bit processor bus. Each 12-bit code reaches the block as two bus transfers. One transfer carries the low eight bits. The other carries the top four bits in the lower half of the byte. The two transfers may come in either order. A channel-select input steers each write to channel A or channel B. A byte-select input steers it to that channel's low-byte or high-nibble holding register.

The holding registers are separate from the 12-bit output registers that drive the converter codes, so the data path is double-buffered. Software can stage new values in both channels, then pulse one shared load strobe. Both output codes then change on the same clock edge. A single asynchronous reset returns both outputs and all holding registers to zero.

All strobes are active-low and are sampled on the rising clock edge.

Top module: `dual_byte_dac_regs`

## Requirements
- R1: After reset is released, both output codes read 0. A load with no intervening write keeps them at 0, which shows that the holding registers were cleared too.
- R2: A write with byteSel=0 stores dataIn[7:0] as bits 7:0 of the selected channel's staged value and leaves bits 11:8 unchanged.
- R3: A write with byteSel=1 stores dataIn[3:0] as bits 11:8 of the staged value. dataIn[7:4] are ignored, and bits 7:0 are left unchanged.
- R4: Writing the low byte first or the high byte first produces the same 12-bit code after a load.
- R5: chSel=0 addresses channel A (codeA) and chSel=1 addresses channel B (codeB). A write never changes the other channel's staged value.
- R6: A write alone never changes codeA or codeB. The outputs hold until the next load or reset.
- R7: On a clock edge where loadN=0, codeA and codeB both take their channel's staged value, in the same cycle.
- R8: When wrN=0 and loadN=0 at the same edge, the outputs take the staged values from before that write, and the write lands in the holding register.
- R9: rstN=0 forces both outputs to 0 at once, without waiting for a clock edge. It overrides any write or load on the same edge.
- R10: While wrN=1, the data, chSel and byteSel inputs have no effect on any staged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 8 | Processor data byte |
| wrN | input | 1 | Write strobe, active low |
| loadN | input | 1 | Shared load strobe for both channels, active low |
| chSel | input | 1 | Channel select: 0 = A, 1 = B |
| byteSel | input | 1 | Byte select: 0 = low byte, 1 = high nibble |
| codeA | output | 12 | Channel A output code |
| codeB | output | 12 | Channel B output code |

## Verification
The assertions check several properties on every cycle:
- Outputs stay stable whenever load is idle.
- Both outputs update from their staged values together on load.
- A high-nibble write keeps the low byte and drops the upper bus bits.
- A write to one channel leaves the other channel's staged value alone.
- Outputs are zero whenever reset is low.

Only the bench's scenarios show some behaviours at the ports:
- Byte order does not change the result.
- A write and a load on the same edge resolve to the staged value from before the write.
- Reset acts between clock edges and also clears the staged values.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic [NUM_CH-1:0] wrLo;
    logic [NUM_CH-1:0] wrHi;
    logic              load;
  } ctrlStrobes_t;
endpackage

// File: rtl/dacreg_ctrl.sv
module dacreg_ctrl
  import dacreg_pkg::*;
(
  input  logic         wrN,
  input  logic         loadN,
  input  logic         chSel,
  input  logic         byteSel,
  output ctrlStrobes_t strobes
);
  // Turn the active-low bus strobes into per-channel, per-half write enables.
  always_comb begin
    strobes = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      strobes.wrLo[ch] = !wrN && !byteSel && (int'(chSel) == ch);
      strobes.wrHi[ch] = !wrN &&  byteSel && (int'(chSel) == ch);
    end
    strobes.load = !loadN;
  end
endmodule

// File: rtl/dacreg_datapath.sv
module dacreg_datapath
  import dacreg_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [BUS_W-1:0]               dataIn,
  input  ctrlStrobes_t                   strobes,
  output logic [NUM_CH-1:0][CODE_W-1:0]  pend,
  output logic [NUM_CH-1:0][CODE_W-1:0]  code
);
  localparam int HI_W = CODE_W - BUS_W;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [BUS_W-1:0] loReg;
    logic [HI_W-1:0]  hiReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loReg <= '0;
      end else if (strobes.wrLo[ch]) begin
        loReg <= dataIn;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiReg <= '0;
      end else if (strobes.wrHi[ch]) begin
        hiReg <= dataIn[HI_W-1:0];
      end
    end

    assign pend[ch] = {hiReg, loReg};

    // The output register samples the staged value from before any
    // write that happens on the same edge.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        code[ch] <= '0;
      end else if (strobes.load) begin
        code[ch] <= pend[ch];
      end
    end
  end
endmodule

// File: rtl/dual_byte_dac_regs.sv
module dual_byte_dac_regs
  import dacreg_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  dataIn,
  input  logic              wrN,
  input  logic              loadN,
  input  logic              chSel,
  input  logic              byteSel,
  output logic [CODE_W-1:0] codeA,
  output logic [CODE_W-1:0] codeB
);
  ctrlStrobes_t                  strobes;
  logic [NUM_CH-1:0][CODE_W-1:0] pend;
  logic [NUM_CH-1:0][CODE_W-1:0] code;
  logic [CODE_W-1:0]             pendA;
  logic [CODE_W-1:0]             pendB;

  dacreg_ctrl u_ctrl (
    .wrN     (wrN),
    .loadN   (loadN),
    .chSel   (chSel),
    .byteSel (byteSel),
    .strobes (strobes)
  );

  dacreg_datapath #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .strobes (strobes),
    .pend    (pend),
    .code    (code)
  );

  assign pendA = pend[0];
  assign pendB = pend[1];
  assign codeA = code[0];
  assign codeB = code[1];
endmodule

// File: rtl/dacreg_checker.sv
module dacreg_checker #(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [BUS_W-1:0]  dataIn,
  input logic              wrN,
  input logic              loadN,
  input logic              chSel,
  input logic              byteSel,
  input logic [CODE_W-1:0] codeA,
  input logic [CODE_W-1:0] codeB,
  input logic [CODE_W-1:0] pendA,
  input logic [CODE_W-1:0] pendB
);
  localparam int HI_W = CODE_W - BUS_W;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    loadN |=> ($stable(codeA) && $stable(codeB)));

  p_load_both_r7: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |=> (codeA == $past(pendA) && codeB == $past(pendB)));

  p_high_nibble_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && byteSel && !chSel) |=>
      (pendA[CODE_W-1:BUS_W] == $past(dataIn[HI_W-1:0]) &&
       pendA[BUS_W-1:0] == $past(pendA[BUS_W-1:0])));

  p_low_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && !byteSel && chSel) |=>
      (pendB[BUS_W-1:0] == $past(dataIn) &&
       pendB[CODE_W-1:BUS_W] == $past(pendB[CODE_W-1:BUS_W])));

  p_other_chan_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && !chSel) |=> $stable(pendB));

  p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrN |=> ($stable(pendA) && $stable(pendB)));

  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_zero_r9: assert (codeA == '0 && codeB == '0);
    end
  end
endmodule

bind dual_byte_dac_regs dacreg_checker #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .dataIn  (dataIn),
  .wrN     (wrN),
  .loadN   (loadN),
  .chSel   (chSel),
  .byteSel (byteSel),
  .codeA   (codeA),
  .codeB   (codeB),
  .pendA   (pendA),
  .pendB   (pendB)
);

// File: tb/dual_byte_dac_regs_test.sv
module dual_byte_dac_regs_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 11;

  // Layout: [35] wrN [34] loadN [33] chSel [32] byteSel [31:24] data
  //         [23:12] expected codeA [11:0] expected codeB (after the edge)
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h5A, 12'h000, 12'h000}, // A low
    {1'b0, 1'b1, 1'b0, 1'b1, 8'hF3, 12'h000, 12'h000}, // A high, top bits dropped
    {1'b0, 1'b1, 1'b1, 1'b1, 8'h0C, 12'h000, 12'h000}, // B high first
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h21, 12'h000, 12'h000}, // B low second
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 12'h35A, 12'hC21}, // load
    {1'b0, 1'b1, 1'b0, 1'b1, 8'h07, 12'h35A, 12'hC21}, // write, no output change
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h99, 12'h75A, 12'hC21}, // write + load together
    {1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 12'h75A, 12'hC21}, // idle bus
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 12'h799, 12'hC21}, // load
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 12'h799, 12'hC21}, // B low only
    {1'b1, 1'b0, 1'b1, 1'b1, 8'hEE, 12'h799, 12'hC00}  // load
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  dataIn;
  logic        wrN, loadN, chSel, byteSel;
  logic [11:0] codeA, codeB;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  dual_byte_dac_regs uut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .wrN(wrN), .loadN(loadN),
    .chSel(chSel), .byteSel(byteSel), .codeA(codeA), .codeB(codeB)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string rowTag(int i);
    case (i)
      0:       return "R2";
      1:       return "R3";
      2, 9:    return "R5";
      3:       return "R4";
      5:       return "R6";
      6:       return "R8";
      7:       return "R10";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%03h expected=%03h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic w, logic l, logic c, logic b, logic [7:0] d);
    wrN = w; loadN = l; chSel = c; byteSel = b; dataIn = d;
    @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; wrN = 1'b1; loadN = 1'b1; chSel = 1'b0; byteSel = 1'b0; dataIn = '0;
    repeat (3) @(negedge clk);
    check("R1", "codeA in reset", codeA, 12'h000);
    check("R1", "codeB in reset", codeB, 12'h000);
    rstN = 1'b1;
    @(negedge clk);

    // Stimulus applied at a falling edge, result sampled at the next one.
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][35], VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:24]);
      check(rowTag(i), $sformatf("row %0d codeA", i), codeA, VEC[i][23:12]);
      check(rowTag(i), $sformatf("row %0d codeB", i), codeB, VEC[i][11:0]);
    end
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);

    // R9: asynchronous clear in the middle of a cycle.
    #(CLK_PERIOD/4) rstN = 1'b0;
    #1;
    check("R9", "codeA async clear", codeA, 12'h000);
    check("R9", "codeB async clear", codeB, 12'h000);
    // R9: reset wins over a write and a load on the same edge.
    wrN = 1'b0; loadN = 1'b0; dataIn = 8'hAB;
    @(negedge clk);
    check("R9", "codeA reset priority", codeA, 12'h000);
    rstN = 1'b1;
    wrN = 1'b1; loadN = 1'b1;
    @(negedge clk);
    // R1: the staged values were cleared, so a load still gives zero.
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R1", "codeA load after reset", codeA, 12'h000);
    check("R1", "codeB load after reset", codeB, 12'h000);

    // R4: the same code written in both byte orders.
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h34);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h12);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h12);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h34);
    check("R6", "codeA before load", codeA, 12'h000);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R4", "codeA low-first", codeA, 12'h234);
    check("R4", "codeB high-first", codeB, 12'h234);

    // R6: outputs hold over idle cycles.
    repeat (4) drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h55);
    check("R6", "codeA holds", codeA, 12'h234);
    check("R6", "codeB holds", codeB, 12'h234);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule